// File: doc/BRIEF.md
# I2C Master Clock Generator with Bus Synchronization

This block derives two timing signals from a fast system clock: a bus sampling tick and the SCL waveform that a bus master drives. A 3-bit exponent divides the system clock by a power of two to give the sampling tick. A 4-bit multiplier then sets how many ticks each half of the SCL period lasts: five ticks times one more than the multiplier. The SCL output is open-drain. The block only ever asks for the line to be pulled low, and it reads the real line level back through `scl_in`.

Both SCL phases are timed against the level actually seen on the bus, so the clock is not free-running. When a slave or a slower master keeps the line low, the high phase is delayed. When any device pulls the line low, the high phase ends early. A hold request from the byte engine keeps the low phase going for as long as it is asserted, which lets the engine stretch the clock at byte boundaries. Three one-cycle strobes mark points in each bit: the rising edge, the middle of the high phase (where SDA is sampled and START/STOP are detected), and the falling edge. Only plain control pins are used. No data stream passes through the block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `i2c_scl_gen`

## Requirements
- R1: While `enable` is high, `sample_tick` pulses for one clock every 2^`div_n` clocks. `div_n`=0 gives a tick on every clock. While `enable` is low there are no ticks.
- R2: While `enable` is low, `scl_drive_low`, `rise_stb`, `mid_stb` and `fall_stb` are all 0 from the next clock on.
- R3: Let H = 5*(`div_m`+1). With no other device on the bus, `scl_drive_low` is held at 1 for H sample ticks, that is H*2^`div_n` clocks. It changes only on a clock where `sample_tick` was high or `enable` is low.
- R4: With no other device on the bus, `scl_drive_low` stays 0 for H sample ticks between its release and the next assertion.
- R5: Clock stretching. After a release, while `scl_in` is sampled low, the block keeps SCL released, does not count, and raises no `rise_stb`. `rise_stb` comes on the first tick that samples `scl_in` high. `scl_drive_low` rises H-1 ticks after that.
- R6: Synchronization. If `scl_in` is sampled low during the high phase, `scl_drive_low` and `fall_stb` are asserted on that tick. A full low phase of H ticks then follows.
- R7: While `hold` is high, the low phase does not end, however long it lasts. After `hold` falls, SCL is released on the next sample tick.
- R8: Each strobe is a one-clock pulse, and at most one strobe is high at a time. `fall_stb` coincides with the clock where `scl_drive_low` becomes 1. With no other device on the bus, `rise_stb` comes 1 tick after the release and `mid_stb` comes floor(H/2)+1 ticks after the release.
- R9: After `enable` rises, the first sample tick starts a low phase. The first assertion of `scl_drive_low` comes with `fall_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the generator; low returns it to idle with SCL released |
| div_n | input | 3 | Sample divider exponent; the tick period is 2^div_n clocks |
| div_m | input | 4 | Phase multiplier; each SCL half lasts 5*(div_m+1) ticks |
| scl_in | input | 1 | Synchronized level of the SCL line |
| hold | input | 1 | Keeps the low phase going for as long as it is high |
| scl_drive_low | output | 1 | 1 pulls SCL low; 0 releases it |
| sample_tick | output | 1 | Bus sampling strobe |
| rise_stb | output | 1 | SCL has been seen high after a release |
| mid_stb | output | 1 | Midpoint of the high phase |
| fall_stb | output | 1 | This block has just started pulling SCL low |

## Verification
Every phase decision is registered on a sample-tick edge, so each result is due a whole number of ticks, times 2^`div_n` clocks, after the tick where its condition was sampled. The strobes and `scl_drive_low` appear one clock after that edge. The bench samples all outputs on falling clock edges. It counts those samples from the falling strobe or from the release, and compares the counts with tick multiples computed from `div_n` and `div_m`. The stretch, cut-short and hold cases change the bus model on a falling edge. The response is then expected on the very next sample, or H-1 ticks later.

// File: rtl/i2c_sclgen_pkg.sv
package i2c_sclgen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } scl_phase_e;
endpackage

// File: rtl/sclgen_prescale.sv
module sclgen_prescale #(
  parameter int N_W = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic [N_W-1:0] div_n,
  output logic           tick
);
  localparam int CW = (1 << N_W) - 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] mask;

  // mask selects the low div_n bits of the free counter
  always_comb begin
    mask = '0;
    for (int i = 0; i < CW; i++) begin
      if (i < int'(div_n)) mask[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!enable) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  assign tick = enable && ((cnt & mask) == mask);

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && enable && div_n != '0) |=> (!tick || !$stable(div_n))); // R1
endmodule

// File: rtl/sclgen_phase.sv
module sclgen_phase
  import i2c_sclgen_pkg::*;
#(
  parameter int M_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic           tick,
  input  logic [M_W-1:0] div_m,
  input  logic           scl_in,
  input  logic           hold,
  output logic           drive_low,
  output logic           rise_stb,
  output logic           mid_stb,
  output logic           fall_stb
);
  localparam int HW = $clog2(5 * (1 << M_W) + 1);

  scl_phase_e      state;
  logic [HW-1:0]   cnt;
  logic [HW-1:0]   half_len;
  logic [HW-1:0]   last_tick;
  logic [HW-1:0]   mid_tick;

  assign half_len  = (HW'(div_m) + HW'(1)) * HW'(5);
  assign last_tick = half_len - HW'(1);
  assign mid_tick  = half_len >> 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= PH_IDLE;
      cnt       <= '0;
      drive_low <= 1'b0;
      rise_stb  <= 1'b0;
      mid_stb   <= 1'b0;
      fall_stb  <= 1'b0;
    end else begin
      rise_stb <= 1'b0;
      mid_stb  <= 1'b0;
      fall_stb <= 1'b0;
      if (!enable) begin
        state     <= PH_IDLE;
        cnt       <= '0;
        drive_low <= 1'b0;
      end else if (tick) begin
        case (state)
          PH_IDLE: begin
            state     <= PH_LOW;
            cnt       <= '0;
            drive_low <= 1'b1;
            fall_stb  <= 1'b1;
          end
          PH_LOW: begin
            // counts only while the line is really low; saturates under hold
            if (!scl_in) begin
              if (cnt == last_tick) begin
                if (!hold) begin
                  state     <= PH_WAIT;
                  cnt       <= '0;
                  drive_low <= 1'b0;
                end
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          PH_WAIT: begin
            // stretched by any device still holding the line
            if (scl_in) begin
              state    <= PH_HIGH;
              cnt      <= HW'(1);
              rise_stb <= 1'b1;
            end
          end
          PH_HIGH: begin
            if (!scl_in || cnt == last_tick) begin
              state     <= PH_LOW;
              cnt       <= '0;
              drive_low <= 1'b1;
              fall_stb  <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
              if (cnt == mid_tick) mid_stb <= 1'b1;
            end
          end
          default: state <= PH_IDLE;
        endcase
      end
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_stb, mid_stb, fall_stb})); // R8
  AST_FALL_WITH_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> drive_low); // R8
  AST_DRIVE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !tick) |=> $stable(drive_low)); // R3
  AST_HOLD_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && hold && drive_low) |=> (drive_low || !enable)); // R7
  AST_STRETCH_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tick && state == PH_WAIT && !scl_in) |=> (!rise_stb && !drive_low)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!drive_low && !rise_stb && !mid_stb && !fall_stb)); // R2
endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen #(
  parameter int N_W = 3,
  parameter int M_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic [N_W-1:0] div_n,
  input  logic [M_W-1:0] div_m,
  input  logic           scl_in,
  input  logic           hold,
  output logic           scl_drive_low,
  output logic           sample_tick,
  output logic           rise_stb,
  output logic           mid_stb,
  output logic           fall_stb
);
  logic tick;

  sclgen_prescale #(.N_W(N_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .div_n  (div_n),
    .tick   (tick)
  );

  sclgen_phase #(.M_W(M_W)) u_ph (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .tick      (tick),
    .div_m     (div_m),
    .scl_in    (scl_in),
    .hold      (hold),
    .drive_low (scl_drive_low),
    .rise_stb  (rise_stb),
    .mid_stb   (mid_stb),
    .fall_stb  (fall_stb)
  );

  assign sample_tick = tick;
endmodule

// File: tb/tb_i2c_scl_gen.sv
module tb_i2c_scl_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [2:0] div_n = '0;
  logic [3:0] div_m = '0;
  logic       hold = 1'b0;
  logic       ext_low = 1'b0;
  logic       scl_in;
  logic       scl_drive_low, sample_tick, rise_stb, mid_stb, fall_stb;
  int         checks = 0;
  int         fails = 0;
  int         cyc = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  // wired-AND bus: low if anyone pulls
  assign scl_in = !(scl_drive_low || ext_low);

  i2c_scl_gen dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .div_n(div_n), .div_m(div_m),
    .scl_in(scl_in), .hold(hold), .scl_drive_low(scl_drive_low),
    .sample_tick(sample_tick), .rise_stb(rise_stb), .mid_stb(mid_stb),
    .fall_stb(fall_stb)
  );

  localparam logic [6:0] VEC [0:5] = '{
    {3'd0, 4'd0}, {3'd1, 4'd0}, {3'd0, 4'd3},
    {3'd2, 4'd1}, {3'd3, 4'd2}, {3'd0, 4'd15}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_fall();
    do @(negedge clk); while (!fall_stb);
  endtask

  task automatic restart(input logic [2:0] n, input logic [3:0] m);
    @(negedge clk);
    enable = 1'b0;
    div_n  = n;
    div_m  = m;
    repeat (2) @(negedge clk);
    enable = 1'b1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // reset state
    repeat (3) @(negedge clk);
    check(scl_drive_low == 0 && rise_stb == 0 && mid_stb == 0 && fall_stb == 0,
          "R2 reset outputs", {scl_drive_low, rise_stb, mid_stb, fall_stb}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(sample_tick == 0, "R1 no tick while disabled", sample_tick, 0);

    // vector table walk
    for (int v = 0; v < 6; v++) begin
      int n, m, p, h, t, tl, tr, tm, tf, tp;
      n = int'(VEC[v][6:4]);
      m = int'(VEC[v][3:0]);
      p = 1 << n;
      h = 5 * (m + 1);
      restart(VEC[v][6:4], VEC[v][3:0]);
      // R9: first drive comes with fall strobe
      do @(negedge clk); while (!scl_drive_low);
      check(fall_stb == 1, "R9 first low with fall_stb", fall_stb, 1);
      // R1 tick period
      while (!sample_tick) @(negedge clk);
      tp = 0;
      do begin @(negedge clk); tp++; end while (!sample_tick);
      check(tp == p, "R1 tick period", tp, p);
      // waveform
      wait_fall();
      t = 0; tl = -1; tr = -1; tm = -1; tf = -1;
      while (tf < 0 && t < 20000) begin
        @(negedge clk);
        t++;
        if (tl < 0 && !scl_drive_low) tl = t;
        if (tl >= 0 && tr < 0 && rise_stb) tr = t;
        if (tl >= 0 && tm < 0 && mid_stb) tm = t;
        if (tl >= 0 && fall_stb) tf = t;
      end
      check(tl == h * p, "R3 low length", tl, h * p);
      check(tf - tl == h * p, "R4 high length", tf - tl, h * p);
      check(tr - tl == p, "R8 rise delay", tr - tl, p);
      check(tm - tl == (h / 2 + 1) * p, "R8 mid delay", tm - tl, (h / 2 + 1) * p);
    end

    // R5 stretch, N=0 M=0 (H=5)
    restart(3'd0, 4'd0);
    wait_fall();
    do @(negedge clk); while (scl_drive_low);
    ext_low = 1'b1;
    begin
      bit bad;
      bad = 1'b0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (scl_drive_low || rise_stb) bad = 1'b1;
      end
      check(!bad, "R5 released and no rise during stretch", bad, 0);
    end
    ext_low = 1'b0;
    @(negedge clk);
    check(rise_stb == 1, "R5 rise on first high sample", rise_stb, 1);
    begin
      int k;
      k = 0;
      do begin @(negedge clk); k++; end while (!scl_drive_low && k < 100);
      check(k == 4, "R5 low resumes H-1 ticks after rise", k, 4);
    end

    // R6 synchronization: other master cuts high phase
    do @(negedge clk); while (!rise_stb);
    ext_low = 1'b1;
    @(negedge clk);
    check(scl_drive_low == 1 && fall_stb == 1, "R6 cut short high phase",
          {scl_drive_low, fall_stb}, 3);
    ext_low = 1'b0;
    begin
      int k;
      k = 0;
      do begin @(negedge clk); k++; end while (scl_drive_low && k < 100);
      check(k == 5, "R6 full low after cut", k, 5);
    end

    // R7 hold
    wait_fall();
    hold = 1'b1;
    begin
      bit bad;
      bad = 1'b0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (!scl_drive_low) bad = 1'b1;
      end
      check(!bad, "R7 hold keeps SCL low", bad, 0);
    end
    hold = 1'b0;
    @(negedge clk);
    check(scl_drive_low == 0, "R7 release on tick after hold", scl_drive_low, 0);

    // R2 disable mid-phase
    wait_fall();
    enable = 1'b0;
    @(negedge clk);
    check(scl_drive_low == 0 && !rise_stb && !mid_stb && !fall_stb,
          "R2 disable releases SCL", scl_drive_low, 0);
    check(sample_tick == 0, "R1 tick stops when disabled", sample_tick, 0);
    begin
      bit bad;
      bad = 1'b0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (scl_drive_low || rise_stb || mid_stb || fall_stb) bad = 1'b1;
      end
      check(!bad, "R2 stays quiet while disabled", bad, 0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule